// File: doc/BRIEF.md
# Pipelined Floating-Point Adder/Subtractor

This block adds or subtracts two normalized floating-point operands, each a sign, a fraction and an exponent, with the value fraction × 2^exponent. The work is split into four register-isolated segments: exponent comparison, alignment of the smaller operand, fraction add/subtract, and normalization. The block accepts one operation per clock with no stall and returns each result exactly four clocks later. It does not round, and it has no special values.

Fractions are FRAC_W-bit magnitudes. The binary point sits left of the MSB, and a normalized fraction has its MSB set. Exponents are EXP_W-bit two's complement. When an exponent leaves its range, the block raises a flag but keeps the pipeline running.

Top module: `fpa_pipe_top`

## Requirements
- R1: A result leaves with valid_o high exactly four rising edges after the edge that captured valid_i high, counting the capturing edge as the first. Cycles without valid input produce cycles without valid output.
- R2: The result exponent starts as the larger of the two operand exponents. When the exponents are equal, operand A is the larger operand. The fraction of the smaller-exponent operand is shifted right by the exponent difference, and the bits shifted out are dropped.
- R3: When the exponent difference is FRAC_W or more, the aligned smaller fraction is zero, so the result equals the larger operand.
- R4: sub_i = 1 computes A − B by inverting the sign of B. sub_i = 0 computes A + B.
- R5: When the effective signs differ, the smaller aligned magnitude is subtracted from the larger one, and the result takes the sign of the larger.
- R6: If the magnitude sum carries out of FRAC_W bits, the fraction shifts right by one and the exponent increments by one.
- R7: A non-zero result with leading zeros is shifted left until its MSB is set, and the exponent is decreased by the shift count.
- R8: A zero result fraction is output as sign 0, exponent 0, fraction 0.
- R9: If an increment would pass the largest exponent (2^(EXP_W−1)−1), ovf_o is set and the exponent stays at that maximum.
- R10: If normalization would take the exponent below −2^(EXP_W−1), unf_o is set and the result is forced to the canonical zero.
- R11: While rst_ni is low, valid_o, ovf_o and unf_o are 0.
- R12: One new operation can be accepted on every clock with no bubble, and every accepted operation produces exactly one result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present on the inputs |
| sub_i | input | 1 | 1 = subtract B from A |
| sign_a_i | input | 1 | Sign of A (1 = negative) |
| frac_a_i | input | FRAC_W | Fraction of A |
| exp_a_i | input | EXP_W | Exponent of A, two's complement |
| sign_b_i | input | 1 | Sign of B |
| frac_b_i | input | FRAC_W | Fraction of B |
| exp_b_i | input | EXP_W | Exponent of B, two's complement |
| valid_o | output | 1 | Result present |
| sign_o | output | 1 | Result sign |
| frac_o | output | FRAC_W | Result fraction, normalized or zero |
| exp_o | output | EXP_W | Result exponent |
| ovf_o | output | 1 | Exponent overflow on this result |
| unf_o | output | 1 | Exponent underflow on this result |

## Verification
The assertions check several properties on every cycle:
- the selected exponent is never below either input exponent;
- an exponent gap of FRAC_W or more leaves a zero aligned fraction;
- the valid bit moves one stage per edge;
- every output fraction is either normalized or the canonical zero;
- an underflow always comes with a zero result.

The assertions cannot show that the values are numerically right. The bench shows this with a sweep that compares every result with a model computed in integers. The sweep covers all exponent pairs of a small configuration, several fraction values, and every combination of signs and sub_i. Directed cases hit overflow, underflow, exact cancellation and a large exponent gap.

// File: rtl/fpa_pkg.sv
package fpa_pkg;
  localparam int DEF_FRAC_W = 24;
  localparam int DEF_EXP_W  = 8;

  typedef enum logic [0:0] {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } fpa_op_e;
endpackage

// File: rtl/fpa_exp_cmp.sv
module fpa_exp_cmp #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    sub_i,
  input  logic                    sign_a_i,
  input  logic [FRAC_W-1:0]       frac_a_i,
  input  logic signed [EXP_W-1:0] exp_a_i,
  input  logic                    sign_b_i,
  input  logic [FRAC_W-1:0]       frac_b_i,
  input  logic signed [EXP_W-1:0] exp_b_i,
  output logic                    valid_o,
  output logic                    big_sign_o,
  output logic [FRAC_W-1:0]       big_frac_o,
  output logic                    small_sign_o,
  output logic [FRAC_W-1:0]       small_frac_o,
  output logic signed [EXP_W-1:0] exp_o,
  output logic [EXP_W:0]          diff_o
);
  import fpa_pkg::*;

  logic                 sign_b_eff;
  logic                 a_ge;
  logic signed [EXP_W:0] ea_x, eb_x;
  logic [EXP_W:0]       diff_d;

  always_comb begin
    sign_b_eff = sign_b_i ^ (fpa_op_e'(sub_i) == OP_SUB);
    a_ge       = exp_a_i >= exp_b_i;
    ea_x       = {exp_a_i[EXP_W-1], exp_a_i};
    eb_x       = {exp_b_i[EXP_W-1], exp_b_i};
    diff_d     = a_ge ? EXP_W'(1) * 0 + (ea_x - eb_x) : (eb_x - ea_x);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      big_sign_o   <= 1'b0;
      big_frac_o   <= '0;
      small_sign_o <= 1'b0;
      small_frac_o <= '0;
      exp_o        <= '0;
      diff_o       <= '0;
    end else begin
      valid_o <= valid_i;
      if (a_ge) begin
        big_sign_o   <= sign_a_i;
        big_frac_o   <= frac_a_i;
        small_sign_o <= sign_b_eff;
        small_frac_o <= frac_b_i;
        exp_o        <= exp_a_i;
      end else begin
        big_sign_o   <= sign_b_eff;
        big_frac_o   <= frac_b_i;
        small_sign_o <= sign_a_i;
        small_frac_o <= frac_a_i;
        exp_o        <= exp_b_i;
      end
      diff_o <= diff_d;
    end
  end

  assert_exp_max_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (exp_o >= $past(exp_a_i)) && (exp_o >= $past(exp_b_i)));
endmodule

// File: rtl/fpa_align.sv
module fpa_align #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    big_sign_i,
  input  logic [FRAC_W-1:0]       big_frac_i,
  input  logic                    small_sign_i,
  input  logic [FRAC_W-1:0]       small_frac_i,
  input  logic signed [EXP_W-1:0] exp_i,
  input  logic [EXP_W:0]          diff_i,
  output logic                    valid_o,
  output logic                    big_sign_o,
  output logic [FRAC_W-1:0]       big_frac_o,
  output logic                    small_sign_o,
  output logic [FRAC_W-1:0]       small_frac_o,
  output logic signed [EXP_W-1:0] exp_o
);
  localparam logic [EXP_W:0] FW_V = (EXP_W+1)'(FRAC_W);

  logic [FRAC_W-1:0] shifted;

  always_comb begin
    if (diff_i >= FW_V) shifted = '0;
    else                shifted = small_frac_i >> diff_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      big_sign_o   <= 1'b0;
      big_frac_o   <= '0;
      small_sign_o <= 1'b0;
      small_frac_o <= '0;
      exp_o        <= '0;
    end else begin
      valid_o      <= valid_i;
      big_sign_o   <= big_sign_i;
      big_frac_o   <= big_frac_i;
      small_sign_o <= small_sign_i;
      small_frac_o <= shifted;
      exp_o        <= exp_i;
    end
  end

  assert_wide_gap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && diff_i >= FW_V) |=> (small_frac_o == '0));
endmodule

// File: rtl/fpa_addsub.sv
module fpa_addsub #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    big_sign_i,
  input  logic [FRAC_W-1:0]       big_frac_i,
  input  logic                    small_sign_i,
  input  logic [FRAC_W-1:0]       small_frac_i,
  input  logic signed [EXP_W-1:0] exp_i,
  output logic                    valid_o,
  output logic                    sign_o,
  output logic [FRAC_W:0]         mag_o,
  output logic signed [EXP_W-1:0] exp_o
);
  logic [FRAC_W:0] mag_d;
  logic            sign_d;

  always_comb begin
    if (big_sign_i == small_sign_i) begin
      mag_d  = {1'b0, big_frac_i} + {1'b0, small_frac_i};
      sign_d = big_sign_i;
    end else if (big_frac_i >= small_frac_i) begin
      mag_d  = {1'b0, big_frac_i} - {1'b0, small_frac_i};
      sign_d = big_sign_i;
    end else begin
      mag_d  = {1'b0, small_frac_i} - {1'b0, big_frac_i};
      sign_d = small_sign_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sign_o  <= 1'b0;
      mag_o   <= '0;
      exp_o   <= '0;
    end else begin
      valid_o <= valid_i;
      sign_o  <= sign_d;
      mag_o   <= mag_d;
      exp_o   <= exp_i;
    end
  end

  // differing signs never produce a carry out
  assert_diff_no_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && big_sign_i != small_sign_i) |=> !mag_o[FRAC_W]);
endmodule

// File: rtl/fpa_norm.sv
module fpa_norm #(
  parameter int FRAC_W = 24,
  parameter int EXP_W  = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    sign_i,
  input  logic [FRAC_W:0]         mag_i,
  input  logic signed [EXP_W-1:0] exp_i,
  output logic                    valid_o,
  output logic                    sign_o,
  output logic [FRAC_W-1:0]       frac_o,
  output logic signed [EXP_W-1:0] exp_o,
  output logic                    ovf_o,
  output logic                    unf_o
);
  localparam int LZ_W  = $clog2(FRAC_W + 1);
  localparam int EXX_W = EXP_W + 2;
  localparam logic signed [EXP_W-1:0] EXP_MAX_V = {1'b0, {(EXP_W-1){1'b1}}};
  localparam logic signed [EXX_W-1:0] EXP_MIN_X = {3'b111, {(EXP_W-1){1'b0}}};

  logic [LZ_W-1:0]          lz;
  logic signed [EXX_W-1:0]  exp_x, lz_x, exp_dec;
  logic                     sign_d, ovf_d, unf_d;
  logic [FRAC_W-1:0]        frac_d;
  logic signed [EXP_W-1:0]  exp_d;

  always_comb begin
    lz = LZ_W'(FRAC_W);
    for (int i = 0; i < FRAC_W; i++) begin
      if (mag_i[i]) lz = LZ_W'(FRAC_W - 1 - i);
    end
  end

  always_comb begin
    exp_x   = {{2{exp_i[EXP_W-1]}}, exp_i};
    lz_x    = EXX_W'(lz);
    exp_dec = exp_x - lz_x;
    sign_d  = sign_i;
    frac_d  = '0;
    exp_d   = exp_i;
    ovf_d   = 1'b0;
    unf_d   = 1'b0;
    if (mag_i == '0) begin
      sign_d = 1'b0;
      exp_d  = '0;
    end else if (mag_i[FRAC_W]) begin
      frac_d = mag_i[FRAC_W:1];
      if (exp_i == EXP_MAX_V) ovf_d = 1'b1;
      else                    exp_d = exp_i + EXP_W'(1);
    end else if (exp_dec < EXP_MIN_X) begin
      unf_d  = 1'b1;
      sign_d = 1'b0;
      exp_d  = '0;
    end else begin
      frac_d = mag_i[FRAC_W-1:0] << lz;
      exp_d  = exp_dec[EXP_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sign_o  <= 1'b0;
      frac_o  <= '0;
      exp_o   <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      sign_o  <= sign_d;
      frac_o  <= frac_d;
      exp_o   <= exp_d;
      ovf_o   <= valid_i & ovf_d;
      unf_o   <= valid_i & unf_d;
    end
  end

  assert_valid_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));
  assert_norm_msb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && frac_o != '0) |-> frac_o[FRAC_W-1]);
  assert_zero_canon_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && frac_o == '0) |-> (exp_o == '0 && !sign_o));
  assert_unf_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (frac_o == '0 && !ovf_o));
endmodule

// File: rtl/fpa_pipe_top.sv
module fpa_pipe_top #(
  parameter int FRAC_W = fpa_pkg::DEF_FRAC_W,
  parameter int EXP_W  = fpa_pkg::DEF_EXP_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    sub_i,
  input  logic                    sign_a_i,
  input  logic [FRAC_W-1:0]       frac_a_i,
  input  logic signed [EXP_W-1:0] exp_a_i,
  input  logic                    sign_b_i,
  input  logic [FRAC_W-1:0]       frac_b_i,
  input  logic signed [EXP_W-1:0] exp_b_i,
  output logic                    valid_o,
  output logic                    sign_o,
  output logic [FRAC_W-1:0]       frac_o,
  output logic signed [EXP_W-1:0] exp_o,
  output logic                    ovf_o,
  output logic                    unf_o
);
  logic                    s1_valid, s1_bsign, s1_ssign;
  logic [FRAC_W-1:0]       s1_bfrac, s1_sfrac;
  logic signed [EXP_W-1:0] s1_exp;
  logic [EXP_W:0]          s1_diff;

  logic                    s2_valid, s2_bsign, s2_ssign;
  logic [FRAC_W-1:0]       s2_bfrac, s2_sfrac;
  logic signed [EXP_W-1:0] s2_exp;

  logic                    s3_valid, s3_sign;
  logic [FRAC_W:0]         s3_mag;
  logic signed [EXP_W-1:0] s3_exp;

  fpa_exp_cmp #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_cmp (
    .clk_i, .rst_ni, .valid_i, .sub_i,
    .sign_a_i, .frac_a_i, .exp_a_i, .sign_b_i, .frac_b_i, .exp_b_i,
    .valid_o(s1_valid), .big_sign_o(s1_bsign), .big_frac_o(s1_bfrac),
    .small_sign_o(s1_ssign), .small_frac_o(s1_sfrac), .exp_o(s1_exp), .diff_o(s1_diff)
  );

  fpa_align #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_align (
    .clk_i, .rst_ni, .valid_i(s1_valid),
    .big_sign_i(s1_bsign), .big_frac_i(s1_bfrac),
    .small_sign_i(s1_ssign), .small_frac_i(s1_sfrac), .exp_i(s1_exp), .diff_i(s1_diff),
    .valid_o(s2_valid), .big_sign_o(s2_bsign), .big_frac_o(s2_bfrac),
    .small_sign_o(s2_ssign), .small_frac_o(s2_sfrac), .exp_o(s2_exp)
  );

  fpa_addsub #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_addsub (
    .clk_i, .rst_ni, .valid_i(s2_valid),
    .big_sign_i(s2_bsign), .big_frac_i(s2_bfrac),
    .small_sign_i(s2_ssign), .small_frac_i(s2_sfrac), .exp_i(s2_exp),
    .valid_o(s3_valid), .sign_o(s3_sign), .mag_o(s3_mag), .exp_o(s3_exp)
  );

  fpa_norm #(.FRAC_W(FRAC_W), .EXP_W(EXP_W)) u_norm (
    .clk_i, .rst_ni, .valid_i(s3_valid), .sign_i(s3_sign), .mag_i(s3_mag), .exp_i(s3_exp),
    .valid_o, .sign_o, .frac_o, .exp_o, .ovf_o, .unf_o
  );
endmodule

// File: tb/tb_fpa_pipe_top.sv
`timescale 1ns/1ps
module tb_fpa_pipe_top;
  localparam int FW   = 6;
  localparam int EW   = 4;
  localparam int EMIN = -(1 << (EW-1));
  localparam int EMAX = (1 << (EW-1)) - 1;
  localparam int PW   = FW + EW + 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, valid_i, sub_i, sign_a_i, sign_b_i;
  logic [FW-1:0] frac_a_i, frac_b_i;
  logic signed [EW-1:0] exp_a_i, exp_b_i;
  logic valid_o, sign_o, ovf_o, unf_o;
  logic [FW-1:0] frac_o;
  logic signed [EW-1:0] exp_o;

  fpa_pipe_top #(.FRAC_W(FW), .EXP_W(EW)) dut (
    .clk_i(clk), .rst_ni, .valid_i, .sub_i,
    .sign_a_i, .frac_a_i, .exp_a_i, .sign_b_i, .frac_b_i, .exp_b_i,
    .valid_o, .sign_o, .frac_o, .exp_o, .ovf_o, .unf_o
  );

  int n_chk = 0, n_err = 0, cyc = 0, n_out = 0, n_in = 0;
  logic [PW-1:0] exp_q[$];
  int            stamp_q[$];
  string         tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  function automatic logic [PW-1:0] model(input int sa, input int fa, input int ea,
                                          input int sb, input int fb, input int eb,
                                          input int sub, output string tag);
    int bs, bf, be, ss, sf, se, d, sm, mag, rs, re, ovf, unf, shl;
    if (ea >= eb) begin bs = sa; bf = fa; be = ea; ss = sb ^ sub; sf = fb; se = eb; end
    else begin bs = sb ^ sub; bf = fb; be = eb; ss = sa; sf = fa; se = ea; end
    d  = be - se;
    sm = (d >= FW) ? 0 : (sf >> d);
    if (bs == ss)      begin mag = bf + sm; rs = bs; end
    else if (bf >= sm) begin mag = bf - sm; rs = bs; end
    else               begin mag = sm - bf; rs = ss; end
    re = be; ovf = 0; unf = 0; shl = 0;
    if (mag == 0) begin
      rs = 0; re = 0; tag = "R8";
    end else if (mag >= (1 << FW)) begin
      mag = mag >> 1;
      if (re == EMAX) ovf = 1; else re = re + 1;
      tag = ovf ? "R9" : "R6";
    end else begin
      while (mag < (1 << (FW-1))) begin mag = mag << 1; re = re - 1; shl = 1; end
      if (re < EMIN) begin unf = 1; mag = 0; re = 0; rs = 0; tag = "R10"; end
      else tag = shl ? "R7" : "R2";
    end
    if (tag == "R2" && d >= FW)  tag = "R3";
    else if (tag == "R2" && bs != ss) tag = "R5";
    return {ovf[0], unf[0], rs[0], re[EW-1:0], mag[FW-1:0]};
  endfunction

  task automatic issue(input int sa, input int fa, input int ea, input int sb,
                       input int fb, input int eb, input int sub, input string tg);
    string t;
    logic [PW-1:0] e;
    @(negedge clk);
    valid_i  = 1'b1;
    sub_i    = sub[0];
    sign_a_i = sa[0]; frac_a_i = FW'(fa); exp_a_i = EW'(ea);
    sign_b_i = sb[0]; frac_b_i = FW'(fb); exp_b_i = EW'(eb);
    e = model(sa, fa, ea, sb, fb, eb, sub, t);
    if (tg != "") t = tg;
    exp_q.push_back(e);
    stamp_q.push_back(cyc);
    tag_q.push_back(t);
    n_in++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
    end
  endtask

  // result monitor, sampled between edges
  always @(negedge clk) begin
    if (rst_ni && valid_o) begin
      n_out++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R1", "unexpected valid_o", 1, 0);
      end else begin
        logic [PW-1:0] e, a;
        int st;
        string t;
        e  = exp_q.pop_front();
        st = stamp_q.pop_front();
        t  = tag_q.pop_front();
        a  = {ovf_o, unf_o, sign_o, exp_o, frac_o};
        check(cyc - st == 4, "R1", "latency", cyc - st, 4);
        check(a === e, t, "result {ovf,unf,sign,exp,frac}", a, e);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL R1 watchdog actual cycle %0d expected completion", cyc);
      summary();
      $finish;
    end
  end

  function automatic int frac_pick(input int sel, input int b);
    if (sel == 0) return 32;
    if (sel == 1) return b ? 50 : 45;
    return 63;
  endfunction

  initial begin
    int gap;
    rst_ni = 1'b0; valid_i = 1'b0; sub_i = 1'b0;
    sign_a_i = 1'b0; sign_b_i = 1'b0; frac_a_i = '0; frac_b_i = '0;
    exp_a_i = '0; exp_b_i = '0;
    valid_i = 1'b1;
    repeat (3) @(negedge clk);
    check(!valid_o, "R11", "valid_o in reset", valid_o, 0);
    check(!ovf_o && !unf_o, "R11", "flags in reset", {ovf_o, unf_o}, 0);
    valid_i = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    idle(2);

    issue(0, 63, 7, 0, 63, 7, 0, "R9");   // carry at max exponent
    issue(0, 33, -8, 0, 32, -8, 1, "R10"); // tiny difference at min exponent
    issue(0, 45, 3, 0, 45, 3, 1, "R4");   // x - x
    issue(0, 45, 3, 1, 45, 3, 0, "R8");   // x + (-x)
    issue(0, 40, 7, 0, 63, -8, 0, "R3");  // gap beyond width
    issue(0, 32, 0, 1, 63, 0, 0, "R5");   // larger magnitude negative
    issue(0, 63, 0, 0, 63, -1, 0, "R6");  // carry out
    issue(0, 32, 2, 0, 48, 2, 1, "R7");   // leading zeros after subtract
    issue(1, 50, -2, 1, 40, 1, 1, "R4");  // -a - (-b)
    idle(6);

    gap = 0;
    for (int ea = EMIN; ea <= EMAX; ea++)
      for (int eb = EMIN; eb <= EMAX; eb++)
        for (int fi = 0; fi < 3; fi++)
          for (int fj = 0; fj < 3; fj++)
            for (int k = 0; k < 8; k++) begin
              issue(k & 1, frac_pick(fi, 0), ea, (k >> 1) & 1, frac_pick(fj, 1), eb,
                    (k >> 2) & 1, "");
              gap++;
              if (gap % 97 == 0) idle(1);
            end
    idle(8);
    check(n_out == n_in && exp_q.size() == 0, "R12", "results vs accepted ops",
          n_out, n_in);
    summary();
    $finish;
  end
endmodule